// File: doc/BRIEF.md
# Mesh Boundary Self-Test Sequencer

This block sits on the edge of a two-dimensional mesh network and drives the four boundary injection points (north, west, south, east) through a fixed series of 26 test configurations. For each configuration it presents one test packet per injection point. Each packet carries a data word that is either a pattern or the complement of that pattern, and a relative destination address. The block also drives two routing-override enables. Each enable forces YX routing in one of the two checkerboard halves of the routers. Together these settings exercise the straight links, the direction-change points and the local resource links of every router in a number of cycles that grows linearly with the mesh rank.

Each configuration is held for a window of rank+1 cycles, or 2·rank+1 cycles for routers with input buffering. Packets leave through a valid/ready handshake per port. A configuration is therefore left only when its window has elapsed and all four packets have been taken, so slow or mesochronous links stall the sequence instead of corrupting it. A start pulse launches the sequence. A sticky done flag marks its end. Response compaction and the network itself lie outside this block.

Top module: `bist_cfg_ctrl`

## Requirements
- R1: After reset all packet valids are 0, both YX enables are 0 and done is 0.
- R2: A start pulse while idle or done launches configuration 0 in the next cycle, and the configurations follow in ascending order 0..25. A start pulse during a run has no effect.
- R3: With all readies held high, each configuration lasts exactly WIN cycles (MESH_N+1, or 2·MESH_N+1 when IN_BUF=1). Done rises 26·WIN cycles after the cycle in which start was sampled.
- R4: Configurations 0 and 1 (straight): N, W, S, E carry pattern, complement, pattern, complement in configuration 0, and every value is complemented in configuration 1. The addresses (dx,dy) are N=(0,-n), W=(n,0), S=(0,n), E=(-n,0).
- R5: Configurations 2..9 (turning): data is pattern on N and W and complement on S and E in even configurations, and the reverse in odd ones. Configurations 2..5 address N=W=(n,-n) and S=E=(-n,n). Configurations 6..9 address N=E=(-n,-n) and W=S=(n,n).
- R6: Enable group 0 is 1 exactly in configurations 2, 3, 6 and 7. Enable group 1 is 1 exactly in configurations 4, 5, 8 and 9. The two are never both high.
- R7: Configurations 10..25 (resource): with r = cfg-10, port k = (r mod 8)/2 (0=N, 1=W, 2=S, 3=E) is readdressed to N=(0,-1), W=(1,0), S=(0,-1) or E=(1,0) and carries the pattern in even and the complement in odd configurations. The other ports keep the straight addresses and carry the complement for r<8 and the pattern for r≥8.
- R8: On entering a configuration every port raises valid. A port's valid, and all data and addresses, stay unchanged until that port sees ready. Valid then drops for the rest of the configuration.
- R9: A configuration is left only once its window has elapsed and all four packets have been accepted. A late ready extends the configuration to the cycle in which that ready arrives.
- R10: Done stays high with all valids and enables low until the next start.
- R11: Every presented data word equals PATTERN or its bitwise complement. Port p occupies bits [p·DATA_W +: DATA_W] of the data bus and [p·ADDR_W +: ADDR_W] of each address bus, and addresses are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the sequence (ignored while running) |
| pkt_ready_i | input | 4 | Per-port acceptance from the network, bit p = port p |
| pkt_valid_o | output | 4 | Per-port packet presented |
| pkt_data_o | output | 4·DATA_W | Test data words, one per port |
| pkt_dx_o | output | 4·ADDR_W | Relative X destination per port |
| pkt_dy_o | output | 4·ADDR_W | Relative Y destination per port |
| yx_grp0_o | output | 1 | Force YX routing in checkerboard group 0 |
| yx_grp1_o | output | 1 | Force YX routing in checkerboard group 1 |
| done_o | output | 1 | Sequence finished, sticky until next start |

## Verification
The properties assume that the network never withdraws a packet it has not yet accepted. They also assume that start is the only input able to move the block out of done. The bench honours this by changing ready only at the negative edge and by stalling a single port for a bounded number of cycles. The bench drives start only as single-cycle pulses, including one pulse in the middle of a run to show that it is ignored. Both the unbuffered and the buffered window lengths are swept through all 26 configurations, and every port's data and address are checked in every cycle where the port is valid.

// File: rtl/bist_cfg_pkg.sv
package bist_cfg_pkg;
  localparam int NUM_PORTS  = 4;
  localparam int NUM_STATES = 26;
  localparam int STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [1:0] {PORT_N = 2'd0, PORT_W = 2'd1, PORT_S = 2'd2, PORT_E = 2'd3} port_e;
  typedef enum logic [1:0] {GRP_STRAIGHT, GRP_TURN_A, GRP_TURN_B, GRP_RES} grp_e;
  typedef enum logic [1:0] {RUN_IDLE, RUN_ACTIVE, RUN_DONE} run_e;
endpackage

// File: rtl/bist_cfg_timer.sv
module bist_cfg_timer #(
  parameter int WIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic last_o
);
  localparam int CNT_W = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);

  logic [CNT_W-1:0] cnt_q;

  // saturates at the last count while packets are still pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i)                     cnt_q <= '0;
    else if (run_i && cnt_q != CNT_LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/bist_cfg_seq.sv
module bist_cfg_seq
  import bist_cfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 win_last_i,
  input  logic [NUM_PORTS-1:0] ready_i,
  output logic [STATE_W-1:0]   state_o,
  output logic                 running_o,
  output logic                 done_o,
  output logic                 restart_o,
  output logic [NUM_PORTS-1:0] valid_o
);
  localparam logic [STATE_W-1:0] LAST_ST = STATE_W'(NUM_STATES - 1);

  run_e                 run_q;
  logic [STATE_W-1:0]   st_q;
  logic [NUM_PORTS-1:0] pend_q;
  logic                 all_taken, advance;

  assign all_taken = ((pend_q & ~ready_i) == '0);
  assign advance   = (run_q == RUN_ACTIVE) && win_last_i && all_taken;
  assign restart_o = (start_i && run_q != RUN_ACTIVE) || (advance && st_q != LAST_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RUN_IDLE;
      st_q   <= '0;
      pend_q <= '0;
    end else begin
      case (run_q)
        RUN_ACTIVE: begin
          pend_q <= pend_q & ~ready_i;
          if (advance) begin
            if (st_q == LAST_ST) begin
              run_q  <= RUN_DONE;
              pend_q <= '0;
            end else begin
              st_q   <= st_q + 1'b1;
              pend_q <= '1;
            end
          end
        end
        default: begin
          if (start_i) begin
            run_q  <= RUN_ACTIVE;
            st_q   <= '0;
            pend_q <= '1;
          end
        end
      endcase
    end
  end

  assign state_o   = st_q;
  assign running_o = (run_q == RUN_ACTIVE);
  assign done_o    = (run_q == RUN_DONE);
  assign valid_o   = pend_q;
endmodule

// File: rtl/bist_cfg_decode.sv
module bist_cfg_decode
  import bist_cfg_pkg::*;
#(
  parameter int                MESH_N  = 4,
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] PATTERN = {(DATA_W/2){2'b01}}
) (
  input  logic [STATE_W-1:0]          state_i,
  input  logic                        running_i,
  output logic [NUM_PORTS*DATA_W-1:0] data_o,
  output logic [NUM_PORTS*ADDR_W-1:0] dx_o,
  output logic [NUM_PORTS*ADDR_W-1:0] dy_o,
  output logic                        yx_grp0_o,
  output logic                        yx_grp1_o
);
  localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(MESH_N);
  localparam logic [ADDR_W-1:0] A_NEG  = ADDR_W'(-MESH_N);
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MONE = ADDR_W'(-1);

  grp_e               grp;
  logic [STATE_W-1:0] rel_turn, rel_res;
  logic [1:0]         res_port;
  logic               res_upper, turning;

  always_comb begin
    if (state_i < STATE_W'(2))       grp = GRP_STRAIGHT;
    else if (state_i < STATE_W'(6))  grp = GRP_TURN_A;
    else if (state_i < STATE_W'(10)) grp = GRP_TURN_B;
    else                             grp = GRP_RES;
  end

  assign rel_turn  = state_i - STATE_W'(2);
  assign rel_res   = state_i - STATE_W'(10);
  assign res_port  = rel_res[2:1];
  assign res_upper = rel_res[3];
  assign turning   = running_i && (grp == GRP_TURN_A || grp == GRP_TURN_B);
  assign yx_grp0_o = turning && !rel_turn[1];
  assign yx_grp1_o = turning &&  rel_turn[1];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              use_pat;
    logic [ADDR_W-1:0] dx, dy;

    always_comb begin
      // straight-path addresses are the default for every group
      dx = (p == PORT_W) ? A_POS : (p == PORT_E) ? A_NEG : '0;
      dy = (p == PORT_N) ? A_NEG : (p == PORT_S) ? A_POS : '0;
      case (grp)
        GRP_STRAIGHT: use_pat = ((p % 2) == 0) ^ state_i[0];
        GRP_TURN_A: begin
          use_pat = (p < 2) ^ state_i[0];
          dx = (p < 2) ? A_POS : A_NEG;
          dy = (p < 2) ? A_NEG : A_POS;
        end
        GRP_TURN_B: begin
          use_pat = (p < 2) ^ state_i[0];
          dx = (p == PORT_W || p == PORT_S) ? A_POS : A_NEG;
          dy = dx;
        end
        default: begin
          if (res_port == 2'(p)) begin
            use_pat = ~state_i[0];
            dx = (p == PORT_W || p == PORT_E) ? A_ONE : '0;
            dy = (p == PORT_N || p == PORT_S) ? A_MONE : '0;
          end else begin
            use_pat = res_upper;
          end
        end
      endcase
    end

    assign data_o[p*DATA_W +: DATA_W] = use_pat ? PATTERN : ~PATTERN;
    assign dx_o[p*ADDR_W +: ADDR_W]   = dx;
    assign dy_o[p*ADDR_W +: ADDR_W]   = dy;
  end
endmodule

// File: rtl/bist_cfg_ctrl.sv
module bist_cfg_ctrl
  import bist_cfg_pkg::*;
#(
  parameter int                MESH_N  = 4,
  parameter bit                IN_BUF  = 1'b0,
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] PATTERN = {(DATA_W/2){2'b01}}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [NUM_PORTS-1:0]        pkt_ready_i,
  output logic [NUM_PORTS-1:0]        pkt_valid_o,
  output logic [NUM_PORTS*DATA_W-1:0] pkt_data_o,
  output logic [NUM_PORTS*ADDR_W-1:0] pkt_dx_o,
  output logic [NUM_PORTS*ADDR_W-1:0] pkt_dy_o,
  output logic                        yx_grp0_o,
  output logic                        yx_grp1_o,
  output logic                        done_o
);
  localparam int WIN = IN_BUF ? (2 * MESH_N + 1) : (MESH_N + 1);

  logic [STATE_W-1:0] state;
  logic               running, restart, win_last;

  bist_cfg_timer #(.WIN(WIN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .clear_i (restart),
    .last_o  (win_last)
  );

  bist_cfg_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .win_last_i (win_last),
    .ready_i    (pkt_ready_i),
    .state_o    (state),
    .running_o  (running),
    .done_o     (done_o),
    .restart_o  (restart),
    .valid_o    (pkt_valid_o)
  );

  bist_cfg_decode #(
    .MESH_N (MESH_N),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PATTERN(PATTERN)
  ) u_decode (
    .state_i   (state),
    .running_i (running),
    .data_o    (pkt_data_o),
    .dx_o      (pkt_dx_o),
    .dy_o      (pkt_dy_o),
    .yx_grp0_o (yx_grp0_o),
    .yx_grp1_o (yx_grp1_o)
  );
endmodule

// File: rtl/bist_cfg_ctrl_chk.sv
module bist_cfg_ctrl_chk #(
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] PATTERN = {(DATA_W/2){2'b01}}
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [3:0]           pkt_ready_i,
  input logic [3:0]           pkt_valid_o,
  input logic [4*DATA_W-1:0]  pkt_data_o,
  input logic [4*ADDR_W-1:0]  pkt_dx_o,
  input logic [4*ADDR_W-1:0]  pkt_dy_o,
  input logic                 yx_grp0_o,
  input logic                 yx_grp1_o,
  input logic                 done_o
);
  assert_yx_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(yx_grp0_o && yx_grp1_o));

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pkt_valid_o == 4'b0 && !yx_grp0_o && !yx_grp1_o));

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_hold_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pkt_valid_o & ~pkt_ready_i)) |=>
      ((pkt_valid_o & $past(pkt_valid_o & ~pkt_ready_i)) == $past(pkt_valid_o & ~pkt_ready_i)));

  assert_hold_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pkt_valid_o & ~pkt_ready_i)) |=>
      ($stable(pkt_data_o) && $stable(pkt_dx_o) && $stable(pkt_dy_o)));

  for (genvar p = 0; p < 4; p++) begin : g_pat
    assert_pattern_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_valid_o[p] |-> (pkt_data_o[p*DATA_W +: DATA_W] == PATTERN ||
                          pkt_data_o[p*DATA_W +: DATA_W] == ~PATTERN));
  end
endmodule

bind bist_cfg_ctrl bist_cfg_ctrl_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .PATTERN(PATTERN)
) u_chk (.*);

// File: tb/bist_cfg_ctrl_test.sv
module bist_cfg_ctrl_test;
  localparam int N    = 4;
  localparam int DW   = 16;
  localparam int AW   = 8;
  localparam int WIN0 = N + 1;
  localparam int WIN1 = 2 * N + 1;
  localparam logic [DW-1:0] PAT = 16'h5555;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] start = 2'b00;
  logic [3:0] ready = 4'hF;
  logic [3:0] v0, v1;
  logic [4*DW-1:0] d0, d1;
  logic [4*AW-1:0] x0, x1, y0, y1;
  logic g00, g01, g10, g11, dn0, dn1;
  bit sel = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bist_cfg_ctrl #(.MESH_N(N), .IN_BUF(1'b0), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[0]), .pkt_ready_i(ready),
    .pkt_valid_o(v0), .pkt_data_o(d0), .pkt_dx_o(x0), .pkt_dy_o(y0),
    .yx_grp0_o(g00), .yx_grp1_o(g01), .done_o(dn0));

  bist_cfg_ctrl #(.MESH_N(N), .IN_BUF(1'b1), .DATA_W(DW), .ADDR_W(AW)) uut_buf (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[1]), .pkt_ready_i(ready),
    .pkt_valid_o(v1), .pkt_data_o(d1), .pkt_dx_o(x1), .pkt_dy_o(y1),
    .yx_grp0_o(g10), .yx_grp1_o(g11), .done_o(dn1));

  wire [3:0]      v  = sel ? v1 : v0;
  wire [4*DW-1:0] d  = sel ? d1 : d0;
  wire [4*AW-1:0] xs = sel ? x1 : x0;
  wire [4*AW-1:0] ys = sel ? y1 : y0;
  wire            g0 = sel ? g10 : g00;
  wire            g1 = sel ? g11 : g01;
  wire            dn = sel ? dn1 : dn0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_pat(int st, int p);
    int r;
    if (st < 2)  return ((p % 2) == 0) ^ (st % 2 == 1);
    if (st < 10) return (p < 2) ^ (st % 2 == 1);
    r = st - 10;
    if (p == (r % 8) / 2) return (st % 2 == 0);
    return (r >= 8);
  endfunction

  function automatic int exp_dx(int st, int p);
    if (st >= 2 && st < 6)  return (p < 2) ? N : -N;
    if (st >= 6 && st < 10) return (p == 1 || p == 2) ? N : -N;
    if (st >= 10 && p == ((st - 10) % 8) / 2) return (p == 1 || p == 3) ? 1 : 0;
    return (p == 1) ? N : (p == 3) ? -N : 0;
  endfunction

  function automatic int exp_dy(int st, int p);
    if (st >= 2 && st < 6)  return (p < 2) ? -N : N;
    if (st >= 6 && st < 10) return (p == 1 || p == 2) ? N : -N;
    if (st >= 10 && p == ((st - 10) % 8) / 2) return (p == 0 || p == 2) ? -1 : 0;
    return (p == 0) ? -N : (p == 2) ? N : 0;
  endfunction

  function automatic string grp_tag(int st);
    if (st < 2)  return "R4 straight";
    if (st < 10) return "R5 turning";
    return "R7 resource";
  endfunction

  // stall_len > 0 holds south ready low for that many cycles of configuration 0
  task automatic run_seq(input bit s, input int stall_len, input int poke_at);
    int win, end0, total, st, age;
    logic [3:0] ev;
    logic [DW-1:0] ed;
    win   = s ? WIN1 : WIN0;
    end0  = (stall_len > win - 1) ? stall_len : win - 1;
    total = end0 + 1 + 25 * win;
    sel   = s;
    ready = (stall_len > 0) ? 4'b1011 : 4'hF;
    @(negedge clk); start[s] = 1'b1;
    @(negedge clk); start[s] = 1'b0;
    for (int c = 0; c <= total; c++) begin
      if (stall_len > 0) ready = (c >= stall_len) ? 4'hF : 4'b1011;
      start[s] = (c == poke_at);
      if (c == total) begin
        chk(dn == 1'b1, "R3 done at 26 windows", dn, 1);
        chk(v == 4'b0, "R10 valid after done", v, 0);
      end else begin
        if (c <= end0) begin st = 0; age = c; end
        else begin st = 1 + (c - end0 - 1) / win; age = (c - end0 - 1) % win; end
        chk(dn == 1'b0, "R3 done early", dn, 0);
        ev = (age == 0) ? 4'hF : 4'h0;
        if (st == 0 && stall_len > 0) ev[2] = (c <= stall_len);
        chk(v == ev, (st == 0 && stall_len > 0) ? "R9 stall valid" : "R8 valid per window", v, ev);
        chk(g0 == (st == 2 || st == 3 || st == 6 || st == 7), "R6 group0 enable", g0,
            (st == 2 || st == 3 || st == 6 || st == 7));
        chk(g1 == (st == 4 || st == 5 || st == 8 || st == 9), "R6 group1 enable", g1,
            (st == 4 || st == 5 || st == 8 || st == 9));
        for (int p = 0; p < 4; p++) begin
          if (ev[p]) begin
            ed = exp_pat(st, p) ? PAT : ~PAT;
            chk(d[p*DW +: DW] == ed, {grp_tag(st), " data"}, d[p*DW +: DW], ed);
            chk(int'($signed(xs[p*AW +: AW])) == exp_dx(st, p), {grp_tag(st), " dx"},
                $signed(xs[p*AW +: AW]), exp_dx(st, p));
            chk(int'($signed(ys[p*AW +: AW])) == exp_dy(st, p), {grp_tag(st), " dy"},
                $signed(ys[p*AW +: AW]), exp_dy(st, p));
          end
        end
      end
      @(negedge clk);
    end
    start[s] = 1'b0;
    ready = 4'hF;
    repeat (4) @(negedge clk);
    chk(dn == 1'b1, "R10 done sticky", dn, 1);
    chk(v == 4'b0 && !g0 && !g1, "R10 quiet while done", {v, g0, g1}, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(v0 == 4'b0 && v1 == 4'b0, "R1 reset valid", {v1, v0}, 0);
    chk(!dn0 && !dn1, "R1 reset done", {dn1, dn0}, 0);
    chk(!g00 && !g01 && !g10 && !g11, "R1 reset yx", {g00, g01, g10, g11}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(v0 == 4'b0 && !dn0, "R2 idle without start", {v0, dn0}, 0);
    run_seq(1'b0, 0, -1);           // R2 R3 unbuffered sweep
    run_seq(1'b1, 0, 40);           // R2 start ignored mid-run, R3 buffered window
    run_seq(1'b0, WIN0 + 3, -1);    // R9 late ready on south port
    run_seq(1'b1, 0, -1);           // R2 restart from done
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule